// File: doc/BRIEF.md
# Modbus RTU CRC-16 Byte Engine

This block computes the 16-bit frame check used on Modbus RTU serial links. It takes one byte per strobe and keeps a running check register. Each byte is folded in by XOR into the low eight bits of the register. The register then takes eight single-bit right-shift steps, and any step that shifts out a one also applies the reflected polynomial 0xA001. A frame starts with an init strobe, which presets the register to all ones. Every byte from the address field through the last data byte is then strobed in.

The engine serves both the sending and the receiving side. When generating, the sender reads the two check bytes in transmission order: `crc_lo_o` goes on the wire first and `crc_hi_o` follows. When checking, the receiver also feeds the two received check bytes through the engine. An intact frame leaves a residue of 0x0000, and in check mode that raises `match_o`.

A parameter picks one of two variants. The iterative variant is built around a two-state controller. State ST_IDLE moves to ST_SHIFT on an accepted byte. ST_SHIFT returns to ST_IDLE after the eighth bit step, or at once on an init strobe. While in ST_SHIFT the block raises `busy_o`. The combinational variant folds all eight steps into the accepting cycle and never leaves ST_IDLE.

Top module: `mbcrc_engine`

## Requirements
- R1: While reset is asserted and directly after it, `crc_o` is 0xFFFF, `busy_o` is 0 and `match_o` is 0.
- R2: An init strobe presets `crc_o` to 0xFFFF on the next clock edge, also in the middle of a frame.
- R3: Each accepted byte updates the register as follows. The byte is XORed into bits 7:0. Then, eight times: if bit 0 is 1, the register becomes (register >> 1) XOR 0xA001, otherwise it becomes register >> 1. From the preset, "123456789" gives 0x4B37, the single byte 0x00 gives 0x40BF and the single byte 0xFF gives 0x00FF.
- R4: In the iterative variant, `busy_o` is high for exactly 8 cycles after the edge that accepts a byte. The updated value is on `crc_o` in the first cycle in which `busy_o` is low again.
- R5: The register changes only on reset, init, an accepted byte, or a shift step. A byte strobed while `busy_o` is high is ignored.
- R6: `crc_lo_o` carries `crc_o` bits 7:0, the byte sent first. `crc_hi_o` carries bits 15:8, the byte sent second.
- R7: Feeding a frame followed by its check bytes, low byte then high byte, leaves `crc_o` at 0x0000. In check mode (`check_mode_i` = 1), with the engine idle, that raises `match_o`.
- R8: In generate mode (`check_mode_i` = 0), `match_o` stays 0 even when the register holds 0x0000.
- R9: An init strobe in the same cycle as a byte strobe wins: the register becomes 0xFFFF and the byte is not folded in.
- R10: An init strobe while `busy_o` is high aborts the byte. `busy_o` is low and `crc_o` is 0xFFFF after the next edge.
- R11: A frame whose check bytes are corrupted leaves a non-zero residue, and `match_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| init_i | input | 1 | Start of frame: preset the register |
| valid_i | input | 1 | Byte strobe |
| data_i | input | 8 | Byte to fold in |
| check_mode_i | input | 1 | 1 = verify received frame, 0 = generate |
| busy_o | output | 1 | Bit steps in progress (iterative variant) |
| crc_o | output | 16 | Running check register |
| crc_lo_o | output | 8 | Check byte sent first |
| crc_hi_o | output | 8 | Check byte sent second |
| match_o | output | 1 | Zero residue seen in check mode |

## Verification
Two of the engine's functions can fall in the same cycle, and both collisions are provoked on purpose. The first is the frame-start preset arriving together with a byte strobe. The second is the preset arriving while the controller is still in ST_SHIFT. For the first, the bench raises both strobes on one falling edge after the register holds a non-preset value. It then judges that `crc_o` reads 0xFFFF with `busy_o` low, so the byte left no trace. For the second, the bench raises init one cycle into a shift run. It judges that `busy_o` drops right after that edge and that the register shows the preset rather than a partly shifted value.

// File: rtl/mbcrc_pkg.sv
package mbcrc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1
    } mbcrc_state_e;

    localparam int unsigned MBCRC_W       = 16;
    localparam int unsigned MBCRC_BYTE_W  = 8;
    localparam logic [15:0] MBCRC_POLY    = 16'hA001;
    localparam logic [15:0] MBCRC_PRESET  = 16'hFFFF;

endpackage

// File: rtl/mbcrc_stepper.sv
module mbcrc_stepper #(
    parameter int unsigned          CRC_W = 16,
    parameter logic [CRC_W-1:0]     POLY  = 16'hA001,
    parameter int unsigned          STEPS = 1
) (
    input  logic [CRC_W-1:0] din,
    output logic [CRC_W-1:0] dout
);

    logic [CRC_W-1:0] stage [0:STEPS];

    assign stage[0] = din;

    // one reflected shift step per stage
    for (genvar s = 0; s < STEPS; s++) begin : g_stage
        assign stage[s+1] = stage[s][0] ? ((stage[s] >> 1) ^ POLY)
                                        : (stage[s] >> 1);
    end

    assign dout = stage[STEPS];

endmodule

// File: rtl/mbcrc_fsm.sv
module mbcrc_fsm
    import mbcrc_pkg::*;
#(
    parameter int unsigned STEPS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic abort_i,
    input  logic start_i,
    output logic busy_o,
    output logic shift_o
);

    localparam int unsigned CNT_W = (STEPS > 1) ? $clog2(STEPS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(STEPS - 1);

    mbcrc_state_e     state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                cnt_d = '0;
                if (!abort_i && start_i) begin
                    state_d = ST_SHIFT;
                end
            end
            ST_SHIFT: begin
                if (abort_i) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end else if (cnt_q == LAST) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        busy_o  = 1'b0;
        shift_o = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_SHIFT: begin
                busy_o  = 1'b1;
                shift_o = !abort_i;
            end
            default:  ;
        endcase
    end

endmodule

// File: rtl/mbcrc_datapath.sv
module mbcrc_datapath #(
    parameter int unsigned      CRC_W     = 16,
    parameter int unsigned      BYTE_W    = 8,
    parameter logic [CRC_W-1:0] POLY      = 16'hA001,
    parameter logic [CRC_W-1:0] PRESET    = 16'hFFFF,
    parameter bit               ITERATIVE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_i,
    input  logic              accept_i,
    input  logic              shift_i,
    input  logic [BYTE_W-1:0] data_i,
    output logic [CRC_W-1:0]  crc_q
);

    localparam int unsigned STEPS_PER_CYCLE = ITERATIVE ? 1 : BYTE_W;

    logic [CRC_W-1:0] folded;
    logic [CRC_W-1:0] step_in;
    logic [CRC_W-1:0] step_out;
    logic [CRC_W-1:0] crc_d;

    assign folded = crc_q ^ {{(CRC_W-BYTE_W){1'b0}}, data_i};

    if (ITERATIVE) begin : g_iter
        assign step_in = crc_q;
        always_comb begin
            if (init_i)        crc_d = PRESET;
            else if (accept_i) crc_d = folded;
            else if (shift_i)  crc_d = step_out;
            else               crc_d = crc_q;
        end
    end else begin : g_par
        assign step_in = folded;
        always_comb begin
            if (init_i)        crc_d = PRESET;
            else if (accept_i) crc_d = step_out;
            else               crc_d = crc_q;
        end
    end

    mbcrc_stepper #(
        .CRC_W (CRC_W),
        .POLY  (POLY),
        .STEPS (STEPS_PER_CYCLE)
    ) u_step (
        .din  (step_in),
        .dout (step_out)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= PRESET;
        else        crc_q <= crc_d;
    end

endmodule

// File: rtl/mbcrc_engine.sv
module mbcrc_engine
    import mbcrc_pkg::*;
#(
    parameter bit ITERATIVE = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    init_i,
    input  logic                    valid_i,
    input  logic [MBCRC_BYTE_W-1:0] data_i,
    input  logic                    check_mode_i,
    output logic                    busy_o,
    output logic [MBCRC_W-1:0]      crc_o,
    output logic [MBCRC_BYTE_W-1:0] crc_lo_o,
    output logic [MBCRC_BYTE_W-1:0] crc_hi_o,
    output logic                    match_o
);

    logic             busy;
    logic             shift;
    logic             accept;
    logic [MBCRC_W-1:0] crc_q;

    // init wins over a byte; bytes during shifting are dropped
    assign accept = valid_i && !busy && !init_i;

    if (ITERATIVE) begin : g_ctrl
        mbcrc_fsm #(
            .STEPS (MBCRC_BYTE_W)
        ) u_fsm (
            .clk     (clk),
            .rst_n   (rst_n),
            .abort_i (init_i),
            .start_i (accept),
            .busy_o  (busy),
            .shift_o (shift)
        );
    end else begin : g_noctrl
        assign busy  = 1'b0;
        assign shift = 1'b0;
    end

    mbcrc_datapath #(
        .CRC_W     (MBCRC_W),
        .BYTE_W    (MBCRC_BYTE_W),
        .POLY      (MBCRC_POLY),
        .PRESET    (MBCRC_PRESET),
        .ITERATIVE (ITERATIVE)
    ) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .init_i   (init_i),
        .accept_i (accept),
        .shift_i  (shift),
        .data_i   (data_i),
        .crc_q    (crc_q)
    );

    assign busy_o   = busy;
    assign crc_o    = crc_q;
    assign crc_lo_o = crc_q[MBCRC_BYTE_W-1:0];
    assign crc_hi_o = crc_q[MBCRC_W-1:MBCRC_W-MBCRC_BYTE_W];
    assign match_o  = check_mode_i && !busy && (crc_q == '0);

endmodule

// File: rtl/mbcrc_engine_chk.sv
module mbcrc_engine_chk #(
    parameter bit ITERATIVE = 1'b1
) (
    input logic        clk,
    input logic        rst_n,
    input logic        init_i,
    input logic        valid_i,
    input logic        check_mode_i,
    input logic        busy_o,
    input logic [15:0] crc_o,
    input logic        match_o
);

    localparam int unsigned STEPS = 8;
    localparam int unsigned RUN_W = $clog2(STEPS + 1) + 1;

    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      run_q <= '0;
        else if (busy_o) run_q <= run_q + 1'b1;
        else             run_q <= '0;
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (crc_o == 16'hFFFF && !busy_o && !match_o));

    // R2
    init_preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_i |=> (crc_o == 16'hFFFF));

    // R9
    init_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (init_i && valid_i) |=> (!busy_o && crc_o == 16'hFFFF));

    // R10
    init_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (init_i && busy_o) |=> !busy_o);

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !valid_i && !init_i) |=> $stable(crc_o));

    // R8
    gen_no_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !check_mode_i |-> !match_o);

    // R4
    busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (run_q < RUN_W'(STEPS)));

    if (ITERATIVE) begin : g_iter_chk
        // R4
        accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (valid_i && !busy_o && !init_i) |=> busy_o);

        // R4
        busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($fell(busy_o) && !$past(init_i)) |-> (run_q == RUN_W'(STEPS)));
    end

endmodule

bind mbcrc_engine mbcrc_engine_chk #(
    .ITERATIVE (ITERATIVE)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .init_i       (init_i),
    .valid_i      (valid_i),
    .check_mode_i (check_mode_i),
    .busy_o       (busy_o),
    .crc_o        (crc_o),
    .match_o      (match_o)
);

// File: tb/mbcrc_engine_test.sv
module mbcrc_engine_test;

    localparam time CLK_PERIOD = 10ns;
    localparam bit  ITER       = 1'b1;
    localparam int  NV         = 6;

    typedef struct packed {
        logic [3:0]  len;
        logic [87:0] bytes;   // first byte in bits 7:0
        logic [15:0] exp;
    } vec_t;

    localparam vec_t VEC [NV] = '{
        '{4'd9,  88'h00_00_39_38_37_36_35_34_33_32_31, 16'h4B37},
        '{4'd11, 88'h4B_37_39_38_37_36_35_34_33_32_31, 16'h0000},
        '{4'd1,  88'h00_00_00_00_00_00_00_00_00_00_00, 16'h40BF},
        '{4'd3,  88'h00_00_00_00_00_00_00_00_40_BF_00, 16'h0000},
        '{4'd1,  88'h00_00_00_00_00_00_00_00_00_00_FF, 16'h00FF},
        '{4'd2,  88'h00_00_00_00_00_00_00_00_00_FF_FF, 16'h0000}
    };

    localparam logic [7:0] FRAME [6] = '{8'h11, 8'h03, 8'h00, 8'h00, 8'h00, 8'h06};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        init_i = 1'b0;
    logic        valid_i = 1'b0;
    logic [7:0]  data_i = '0;
    logic        check_mode_i = 1'b0;
    logic        busy_o;
    logic [15:0] crc_o;
    logic [7:0]  crc_lo_o;
    logic [7:0]  crc_hi_o;
    logic        match_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mbcrc_engine #(.ITERATIVE(ITER)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .init_i       (init_i),
        .valid_i      (valid_i),
        .data_i       (data_i),
        .check_mode_i (check_mode_i),
        .busy_o       (busy_o),
        .crc_o        (crc_o),
        .crc_lo_o     (crc_lo_o),
        .crc_hi_o     (crc_hi_o),
        .match_o      (match_o)
    );

    function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r;
        r = c ^ {8'h00, b};
        for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ 16'hA001) : (r >> 1);
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_init();
        @(negedge clk); init_i = 1'b1;
        @(negedge clk); init_i = 1'b0;
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk); valid_i = 1'b1; data_i = b;
        @(negedge clk); valid_i = 1'b0;
        while (busy_o) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] model;
        int          n;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 crc", crc_o, 16'hFFFF);
        chk("R1 busy", busy_o, 0);
        chk("R1 match", match_o, 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk("R1 crc after release", crc_o, 16'hFFFF);

        // table walk: R3 values and R7 residues
        check_mode_i = 1'b1;
        for (int v = 0; v < NV; v++) begin
            do_init();
            for (int i = 0; i < int'(VEC[v].len); i++) send(VEC[v].bytes[8*i +: 8]);
            chk(VEC[v].exp == 16'h0 ? "R7 residue" : "R3 value", crc_o, VEC[v].exp);
            chk("R7 match", match_o, (VEC[v].exp == 16'h0) ? 1 : 0);
        end

        // R6 byte order after "123456789"
        do_init();
        for (int i = 0; i < 9; i++) send(8'h31 + 8'(i));
        chk("R6 low byte", crc_lo_o, 8'h37);
        chk("R6 high byte", crc_hi_o, 8'h4B);

        // R2 init mid-frame
        do_init();
        chk("R2 preset", crc_o, 16'hFFFF);

        // frame check with bench model, R3 and R7
        model = 16'hFFFF;
        for (int i = 0; i < 6; i++) begin
            send(FRAME[i]);
            model = ref_crc(model, FRAME[i]);
        end
        chk("R3 frame", crc_o, model);
        send(crc_lo_o);
        send(8'(model >> 8));
        chk("R7 frame residue", crc_o, 16'h0000);
        chk("R7 match", match_o, 1);
        // R8 generate mode, same zero residue
        check_mode_i = 1'b0;
        @(negedge clk);
        chk("R8 no match", match_o, 0);
        chk("R8 residue held", crc_o, 16'h0000);
        check_mode_i = 1'b1;

        // R11 corrupted check byte
        do_init();
        for (int i = 0; i < 9; i++) send(8'h31 + 8'(i));
        send(8'h37);
        send(8'h4C);
        chk("R11 match", match_o, 0);
        chk("R11 nonzero", (crc_o != 16'h0) ? 1 : 0, 1);

        if (ITER) begin
            // R4 busy length
            do_init();
            @(negedge clk); valid_i = 1'b1; data_i = 8'h00;
            @(negedge clk); valid_i = 1'b0;
            n = 0;
            while (busy_o) begin n++; @(negedge clk); end
            chk("R4 busy cycles", n, 8);
            chk("R4 value", crc_o, 16'h40BF);

            // R5 byte during busy ignored
            do_init();
            @(negedge clk); valid_i = 1'b1; data_i = 8'h00;
            @(negedge clk); data_i = 8'hFF;
            chk("R5 busy", busy_o, 1);
            @(negedge clk); valid_i = 1'b0;
            while (busy_o) @(negedge clk);
            chk("R5 ignored", crc_o, 16'h40BF);

            // R10 init during busy
            do_init();
            @(negedge clk); valid_i = 1'b1; data_i = 8'h31;
            @(negedge clk); valid_i = 1'b0; init_i = 1'b1;
            @(negedge clk); init_i = 1'b0;
            chk("R10 busy", busy_o, 0);
            chk("R10 crc", crc_o, 16'hFFFF);
        end

        // R9 init with byte
        do_init();
        send(8'h31);
        @(negedge clk); init_i = 1'b1; valid_i = 1'b1; data_i = 8'hAA;
        @(negedge clk); init_i = 1'b0; valid_i = 1'b0;
        chk("R9 crc", crc_o, 16'hFFFF);
        chk("R9 busy", busy_o, 0);
        @(negedge clk);
        chk("R9 held", crc_o, 16'hFFFF);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule